// File: doc/BRIEF.md
# Maskable Multi-Source Interrupt Unit

This block gathers eight interrupt causes of equal rank into sticky status flags and drives one interrupt line toward a host. Each cause is remembered whether or not it is enabled; a per-source mask in the enable register decides only which remembered causes reach the line. Software finds the cause by reading the status register. That read also clears the flags, and it should follow every enable write.

Two causes come from comparators inside the block. One matches the sequencer's instruction index, announced by a step strobe, against a 3-bit field of the enable register. It raises its flag in the cycle after the strobe, so the flag appears before that instruction runs. The other watches the conversion FIFO occupancy against a 5-bit fill threshold in the enable register. The remaining causes are a limit-crossing pulse and five general event pulses. The register port is a plain strobe interface with no back-pressure: a write takes effect at the clock edge, and read data comes back one cycle after the read strobe, marked by a valid pin.

Top module: `irq_unit`

## Requirements
- R1: After reset the enable register reads 0, every status flag is 0 and `irq` is low.
- R2: A write to address 4'h4 loads all 16 enable bits, which read back exactly as written. Read data and `rd_valid` appear in the cycle after `rd_en`.
- R3: Address 4'h5 returns the status flags in bits 7:0, with bits 15:8 reading 0. The read clears every flag that has no new event in that cycle.
- R4: A flag is set by its event whatever its enable bit holds, and stays set until a status read.
- R5: `irq` is high exactly when some status flag n has enable bit n (for n from 0 to 7) set.
- R6: A `limit_evt` pulse sets flag 0.
- R7: A `seq_step` pulse whose `seq_index` equals enable bits 10:8 sets flag 1, visible in the next cycle.
- R8: Flag 2 is set in the cycle in which `fifo_count` changes to the value of enable bits 15:11. A count that stays at that value sets nothing more.
- R9: A fill threshold of 0 never sets flag 2.
- R10: An event in the same cycle as a status read is absent from that read's data and is set in the flags afterwards.
- R11: Bit k of `gen_evt` sets flag k+3.
- R12: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with rd_valid |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| limit_evt | input | 1 | Limit-crossing event pulse (source 0) |
| seq_step | input | 1 | Sequencer presents a new instruction index |
| seq_index | input | 3 | Sequencer instruction index |
| fifo_count | input | 6 | Conversion FIFO occupancy |
| gen_evt | input | 5 | General event pulses (sources 3 to 7) |
| irq | output | 1 | Interrupt line, active high |

## Verification
Every cycle, the assertions check that flags persist between status reads and that a status read leaves only the same-cycle events behind. They also check that a zero threshold never raises the FIFO flag, that a limit pulse always lands in flag 0, and that enable writes and read timing behave as stated. The bench scenarios cover what needs a chosen history: a FIFO count walking up to its threshold and then holding there, index steps that miss and then hit the match value, and masking that hides one cause but passes another. They also cover the exact data returned by a read that coincides with an event.

// File: rtl/irq_unit_pkg.sv
package irq_unit_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_SRC  = 8;
  localparam int NUM_GEN  = 5;
  localparam int IDX_W    = 3;
  localparam int THR_W    = 5;
  localparam int SRC_LIM  = 0;
  localparam int SRC_SEQ  = 1;
  localparam int SRC_FIFO = 2;
  localparam int SRC_GEN0 = 3;

  // Field layout of the enable register, most significant first.
  typedef struct packed {
    logic [THR_W-1:0]   fifo_thr;   // bits 15:11
    logic [IDX_W-1:0]   seq_match;  // bits 10:8
    logic [NUM_SRC-1:0] mask;       // bits 7:0
  } irq_en_t;
endpackage

// File: rtl/irq_thresh_detect.sv
module irq_thresh_detect
  import irq_unit_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  irq_en_t          en,
  input  logic             seq_step,
  input  logic [IDX_W-1:0] seq_index,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             seq_hit,
  output logic             fifo_hit
);
  localparam int PAD_W = CNT_W - THR_W;

  logic [CNT_W-1:0] count_prev;
  logic [CNT_W-1:0] thr_ext;
  logic             thr_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_prev <= '0;
    else        count_prev <= fifo_count;
  end

  assign thr_ext   = {{PAD_W{1'b0}}, en.fifo_thr};
  assign thr_valid = (en.fifo_thr != '0);

  always_comb begin
    seq_hit  = seq_step && (seq_index == en.seq_match);
    fifo_hit = thr_valid && (fifo_count == thr_ext) && (count_prev != fifo_count);
  end
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic         clr_i,
  output logic [N-1:0] flags_o
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_o[i] <= 1'b0;
      else        flags_o[i] <= set_i[i] | (flags_o[i] & ~clr_i);
    end
  end
endmodule

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_unit_pkg::*;
#(
  parameter int              ADDR_W   = 4,
  parameter logic [ADDR_W-1:0] ADDR_EN  = 4'h4,
  parameter logic [ADDR_W-1:0] ADDR_STS = 4'h5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               rd_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [REG_W-1:0]   wdata,
  input  logic [NUM_SRC-1:0] flags,
  output irq_en_t            en_q,
  output logic               sts_clr,
  output logic [REG_W-1:0]   rdata,
  output logic               rd_valid
);
  localparam int PAD_W = REG_W - NUM_SRC;

  logic [REG_W-1:0] rd_mux;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         en_q <= '0;
    else if (wr_en && addr == ADDR_EN)  en_q <= wdata;
  end

  always_comb begin
    unique case (addr)
      ADDR_EN:  rd_mux = en_q;
      ADDR_STS: rd_mux = {{PAD_W{1'b0}}, flags};
      default:  rd_mux = '0;
    endcase
  end

  assign sts_clr = rd_en && (addr == ADDR_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import irq_unit_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  output logic [REG_W-1:0]    rdata,
  output logic                rd_valid,
  input  logic                limit_evt,
  input  logic                seq_step,
  input  logic [IDX_W-1:0]    seq_index,
  input  logic [CNT_W-1:0]    fifo_count,
  input  logic [NUM_GEN-1:0]  gen_evt,
  output logic                irq
);
  irq_en_t            en_q;
  logic [REG_W-1:0]   en_bits;
  logic [NUM_SRC-1:0] flags_q;
  logic [NUM_SRC-1:0] src_set;
  logic               sts_clr;
  logic               seq_hit;
  logic               fifo_hit;

  assign en_bits = en_q;

  irq_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flags(flags_q), .en_q(en_q), .sts_clr(sts_clr),
    .rdata(rdata), .rd_valid(rd_valid)
  );

  irq_thresh_detect #(.CNT_W(CNT_W)) u_thresh (
    .clk(clk), .rst_n(rst_n), .en(en_q), .seq_step(seq_step),
    .seq_index(seq_index), .fifo_count(fifo_count),
    .seq_hit(seq_hit), .fifo_hit(fifo_hit)
  );

  always_comb begin
    src_set           = '0;
    src_set[SRC_LIM]  = limit_evt;
    src_set[SRC_SEQ]  = seq_hit;
    src_set[SRC_FIFO] = fifo_hit;
    for (int k = 0; k < NUM_GEN; k++) src_set[SRC_GEN0 + k] = gen_evt[k];
  end

  irq_flag_bank #(.N(NUM_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(src_set), .clr_i(sts_clr), .flags_o(flags_q)
  );

  assign irq = |(flags_q & en_q.mask);
endmodule

// File: rtl/irq_unit_checker.sv
module irq_unit_checker #(
  parameter int          ADDR_W   = 4,
  parameter logic [3:0]  ADDR_EN  = 4'h4,
  parameter logic [3:0]  ADDR_STS = 4'h5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [15:0]       wdata,
  input logic              rd_valid,
  input logic              irq,
  input logic [15:0]       enable,
  input logic [7:0]        flags,
  input logic [7:0]        src_set
);
  logic sts_rd;
  assign sts_rd = rd_en && (addr == ADDR_STS);

  p_rdvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_enable_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_EN) |=> enable == $past(wdata));
  p_read_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_rd && src_set == 8'h00) |=> flags == 8'h00);
  p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_rd |=> (flags & $past(flags)) == $past(flags));
  p_masked_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (enable[7:0] == 8'h00) |-> !irq);
  p_irq_has_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> flags != 8'h00);
  p_limit_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    src_set[0] |=> flags[0]);
  p_zero_thr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[2]) |-> $past(enable[15:11]) != 5'd0);
  p_same_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    sts_rd |=> flags == $past(src_set));
endmodule

bind irq_unit irq_unit_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rd_valid(rd_valid), .irq(irq), .enable(en_bits),
  .flags(flags_q), .src_set(src_set)
);

// File: tb/irq_unit_bench.sv
module irq_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        rd_valid;
  logic        limit_evt = 1'b0, seq_step = 1'b0;
  logic [2:0]  seq_index = '0;
  logic [5:0]  fifo_count = '0;
  logic [4:0]  gen_evt = '0;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  localparam logic [3:0] A_EN = 4'h4, A_STS = 4'h5;

  always #2 clk = ~clk;  // 250 MHz

  irq_unit u_irq_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid), .limit_evt(limit_evt),
    .seq_step(seq_step), .seq_index(seq_index), .fifo_count(fifo_count),
    .gen_evt(gen_evt), .irq(irq)
  );

  // Monitor: pops the expected read data when the design returns a read.
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected read data actual=%h expected=none", rdata);
      end else begin
        logic [15:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s: read actual=%h expected=%h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] e, input string t);
    @(negedge clk); rd_en = 1'b1; addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s: irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk_irq(1'b0, "R1");
    rd(A_EN,  16'h0000, "R1");
    rd(A_STS, 16'h0000, "R1");

    // R2: full readback
    wr(A_EN, 16'hA5C3);
    rd(A_EN, 16'hA5C3, "R2");
    wr(A_EN, 16'h0000);
    rd(A_STS, 16'h0000, "R3");

    // R6 / R4: limit event sets flag 0 while masked
    @(negedge clk); limit_evt = 1'b1; @(negedge clk); limit_evt = 1'b0;
    chk_irq(1'b0, "R5");
    rd(A_STS, 16'h0001, "R6");
    rd(A_STS, 16'h0000, "R3");

    // R11: general events
    @(negedge clk); gen_evt = 5'b10101; @(negedge clk); gen_evt = '0;
    rd(A_STS, 16'h00A8, "R11");

    // R5: masking
    wr(A_EN, 16'h0008);
    rd(A_STS, 16'h0000, "R3");
    @(negedge clk); gen_evt = 5'b00001; @(negedge clk); gen_evt = '0;
    chk_irq(1'b1, "R5");
    rd(A_STS, 16'h0008, "R4");
    chk_irq(1'b0, "R3");
    @(negedge clk); gen_evt = 5'b00010; @(negedge clk); gen_evt = '0;
    chk_irq(1'b0, "R5");
    rd(A_STS, 16'h0010, "R4");

    // R7: index match, flag visible the cycle after the step
    wr(A_EN, 16'h0502);
    rd(A_STS, 16'h0000, "R3");
    @(negedge clk); seq_step = 1'b1; seq_index = 3'd3; @(negedge clk); seq_step = 1'b0;
    chk_irq(1'b0, "R7");
    @(negedge clk); seq_step = 1'b1; seq_index = 3'd5; @(negedge clk); seq_step = 1'b0;
    chk_irq(1'b1, "R7");
    rd(A_STS, 16'h0002, "R7");

    // R8: FIFO count reaching threshold 7, then holding
    wr(A_EN, 16'h3800);
    rd(A_STS, 16'h0000, "R3");
    for (int c = 5; c <= 7; c++) begin @(negedge clk); fifo_count = 6'(c); end
    @(negedge clk);
    rd(A_STS, 16'h0004, "R8");
    repeat (4) @(negedge clk);
    rd(A_STS, 16'h0000, "R8");
    @(negedge clk); fifo_count = 6'd8;
    @(negedge clk);

    // R9: threshold zero, count falls to 0
    wr(A_EN, 16'h0000);
    @(negedge clk); fifo_count = 6'd1;
    @(negedge clk); fifo_count = 6'd0;
    @(negedge clk);
    rd(A_STS, 16'h0000, "R9");

    // R10: event coinciding with a status read
    @(negedge clk); rd_en = 1'b1; addr = A_STS; limit_evt = 1'b1;
    exp_q.push_back(16'h0000); tag_q.push_back("R10");
    @(negedge clk); rd_en = 1'b0; limit_evt = 1'b0;
    rd(A_STS, 16'h0001, "R10");

    // R12: unmapped address
    rd(4'h0, 16'h0000, "R12");
    rd(4'hF, 16'h0000, "R12");

    repeat (3) @(negedge clk);
    checks++;
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2: pending reads actual=%0d expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule